// File: doc/BRIEF.md
# Accumulator ALU with Dual-Lane Mode and Signed Barrel Shifter

This block is the arithmetic and logic stage of a signal-processing datapath. It works on 40-bit accumulator values. It can add, subtract, AND, OR or XOR two operands, shift one operand by a signed count, or move an operand to the result. The second operand comes either from a 40-bit accumulator input or from a sign-extended 16-bit immediate. Optional rounding to a 16-bit boundary and optional saturation to the signed 32-bit range follow the arithmetic. A dual mode splits the low 32 bits into two independent 16-bit lanes, so that two short additions or subtractions finish in the same cycle.

All results are registered. A new operation may be presented on every cycle, and its result, carry and overflow appear one clock later. No operation holds state into the next one.

Top module: `dsp_alu40`

## Requirements
- R1: The outputs are registered. `result_o`, `carry_o` and `ovf_o` show the operation presented at the previous rising clock edge. An input change between edges does not alter them. An active-low asynchronous `rst_n` clears all three outputs to zero.
- R2: Opcode 0 adds and opcode 1 subtracts (A minus B), modulo 2^40. `carry_o` is the unsigned carry out of bit 39. For a subtraction it is 1 when no borrow occurs, that is when A is greater than or equal to B unsigned.
- R3: For addition and subtraction, `ovf_o` is 1 exactly when bit 39 of the wrapped result differs from the sign of the exact signed result.
- R4: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of the two operands. They drive `carry_o` and `ovf_o` to 0, and the saturate, round and dual inputs have no effect on them.
- R5: When `imm_sel_i` is 1, the B operand is `imm_i` sign-extended to 40 bits in place of `acc_b_i`. Opcodes 6 and 7 move the B operand to the result, with carry and overflow 0.
- R6: Opcode 5 shifts A by `shamt_i`, read as a 6-bit two's-complement count from -32 to +31. A positive count shifts left and fills with zeros. A negative count shifts right arithmetically. `ovf_o` is 1 when a left shift loses significant bits, and `carry_o` is 0.
- R7: In dual mode with opcode 0 or 1, bits 15:0 and bits 31:16 are computed as separate 16-bit lanes with no carry between them. Bits 39:32 copy bit 31. `carry_o` is the upper lane's carry (no-borrow for subtraction), and `ovf_o` is the OR of the two lane overflows. Dual mode has no effect on the other opcodes.
- R8: With `rnd_i` set and dual mode off, opcodes 0, 1 and 5 add 0x8000 to the result and then clear bits 15:0. Rounding is skipped in dual mode.
- R9: With `sat_i` set and dual mode off, opcodes 0, 1 and 5 clamp the result to the signed 32-bit range (0x007FFFFFFF or 0xFF80000000). When a 40-bit overflow occurred, the clamp follows the sign of the exact result. `ovf_o` is left as defined in R3 and R6.
- R10: With `sat_i` set in dual mode, each lane that overflowed is clamped on its own to 0x7FFF or 0x8000, following the sign of its exact result. A lane that did not overflow keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift, 6/7 move B |
| dual_i | input | 1 | Two 16-bit lanes for add/sub |
| sat_i | input | 1 | Saturation enable |
| rnd_i | input | 1 | Rounding enable |
| imm_sel_i | input | 1 | Use immediate as B operand |
| imm_i | input | 16 | Signed immediate value |
| shamt_i | input | 6 | Signed shift count, -32..+31 |
| acc_a_i | input | 40 | Operand A |
| acc_b_i | input | 40 | Operand B (accumulator) |
| result_o | output | 40 | Registered result |
| carry_o | output | 1 | Registered carry / no-borrow |
| ovf_o | output | 1 | Registered 40-bit or lane overflow |

## Verification
Every result, carry and overflow value is due exactly one rising edge after its operands are applied. Only the output register lies between the inputs and the pins. The bench drives each operation on a falling edge, lets one rising edge pass and samples on the following falling edge. A directed test changes the inputs between edges and confirms that the outputs still hold the previous result until the next edge. A second directed test pulls reset low mid-cycle and expects zeros before any further edge.

// File: rtl/alu40_pkg.sv
package alu40_pkg;
    localparam int DATA_W  = 40;
    localparam int LANE_W  = 16;
    localparam int SAT_W   = 32;
    localparam int SHIFT_W = 6;
    localparam int IMM_W   = 16;
    localparam int OP_W    = 3;
    localparam int LANES   = SAT_W / LANE_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_SHIFT = 3'd5,
        OP_MOVE  = 3'd6,
        OP_MOVE2 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              carry;
        logic              ovf;
    } alu_out_t;
endpackage

// File: rtl/alu40_addsub.sv
module alu40_addsub #(
    parameter int W     = 40,
    parameter int L     = 16,
    parameter int NLANE = 2
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             sub_i,
    output logic [W-1:0]     res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             neg_o,
    output logic [W-1:0]     dres_o,
    output logic             dcarry_o,
    output logic [NLANE-1:0] lane_ovf_o,
    output logic [NLANE-1:0] lane_neg_o
);
    localparam int DW = NLANE * L;

    logic [W-1:0] bop;
    logic [W:0]   usum;
    logic [DW-1:0] lane_res;

    assign bop   = sub_i ? ~b_i : b_i;
    assign usum  = {1'b0, a_i} + {1'b0, bop} + {{W{1'b0}}, sub_i};
    assign res_o   = usum[W-1:0];
    assign carry_o = usum[W];
    assign ovf_o   = (a_i[W-1] == bop[W-1]) && (usum[W-1] != a_i[W-1]);
    assign neg_o   = ovf_o ? a_i[W-1] : usum[W-1];

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic [L-1:0] la, lb, lr;
        assign la = a_i[k*L +: L];
        assign lb = bop[k*L +: L];
        if (k == NLANE - 1) begin : g_top
            logic [L:0] ls;
            assign ls       = {1'b0, la} + {1'b0, lb} + {{L{1'b0}}, sub_i};
            assign lr       = ls[L-1:0];
            assign dcarry_o = ls[L];
        end else begin : g_low
            assign lr = la + lb + {{(L-1){1'b0}}, sub_i};
        end
        assign lane_res[k*L +: L] = lr;
        assign lane_ovf_o[k] = (la[L-1] == lb[L-1]) && (lr[L-1] != la[L-1]);
        assign lane_neg_o[k] = lane_ovf_o[k] ? la[L-1] : lr[L-1];
    end

    assign dres_o = {{(W-DW){lane_res[DW-1]}}, lane_res};
endmodule

// File: rtl/alu40_shifter.sv
module alu40_shifter #(
    parameter int W  = 40,
    parameter int SW = 6
) (
    input  logic [W-1:0]  a_i,
    input  logic [SW-1:0] cnt_i,
    output logic [W-1:0]  res_o,
    output logic          ovf_o,
    output logic          neg_o
);
    logic [SW:0] mag;

    always_comb begin
        if (cnt_i[SW-1]) begin
            mag   = (SW+1)'(0) - {cnt_i[SW-1], cnt_i};
            res_o = $signed(a_i) >>> mag;
            ovf_o = 1'b0;
        end else begin
            mag   = {1'b0, cnt_i};
            res_o = a_i << mag;
            ovf_o = ($signed(res_o) >>> mag) != $signed(a_i);
        end
    end

    assign neg_o = a_i[W-1];
endmodule

// File: rtl/alu40_post.sv
module alu40_post #(
    parameter int W     = 40,
    parameter int L     = 16,
    parameter int SATW  = 32,
    parameter int NLANE = 2
) (
    input  logic [W-1:0]     res_i,
    input  logic             ovf_i,
    input  logic             neg_i,
    input  logic             dual_i,
    input  logic [NLANE-1:0] lane_ovf_i,
    input  logic [NLANE-1:0] lane_neg_i,
    input  logic             rnd_i,
    input  logic             sat_i,
    output logic [W-1:0]     res_o,
    output logic             ovf_o
);
    localparam logic [W-1:0] POS_LIM  = {{(W-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM  = ~POS_LIM;
    localparam logic [L-1:0] LANE_MAX = {1'b0, {(L-1){1'b1}}};
    localparam logic [L-1:0] LANE_MIN = ~LANE_MAX;
    localparam logic [W:0]   RND_ADD  = (W+1)'(1) << (L-1);

    logic [W:0]   t;
    logic [W-1:0] r;
    logic         neg;
    logic [W-SATW:0] top;

    always_comb begin
        r     = res_i;
        ovf_o = ovf_i;
        neg   = neg_i;
        t     = {res_i[W-1], res_i} + RND_ADD;
        t[L-1:0] = '0;
        if (rnd_i && !dual_i) begin
            if (!ovf_i && (t[W] != t[W-1])) begin
                ovf_o = 1'b1;
                neg   = 1'b0;
            end
            r = t[W-1:0];
        end
        top = r[W-1:SATW-1];
        if (sat_i) begin
            if (dual_i) begin
                for (int k = 0; k < NLANE; k++) begin
                    if (lane_ovf_i[k]) begin
                        r[k*L +: L] = lane_neg_i[k] ? LANE_MIN : LANE_MAX;
                    end
                end
                r[W-1:SATW] = {(W-SATW){r[SATW-1]}};
            end else if (ovf_o) begin
                r = neg ? NEG_LIM : POS_LIM;
            end else if (!((&top) || !(|top))) begin
                r = r[W-1] ? NEG_LIM : POS_LIM;
            end
        end
        res_o = r;
    end
endmodule

// File: rtl/dsp_alu40.sv
module dsp_alu40
    import alu40_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_i,
    input  logic                dual_i,
    input  logic                sat_i,
    input  logic                rnd_i,
    input  logic                imm_sel_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [SHIFT_W-1:0]  shamt_i,
    input  logic [DATA_W-1:0]   acc_a_i,
    input  logic [DATA_W-1:0]   acc_b_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o,
    output logic                ovf_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] b_eff;

    logic [DATA_W-1:0] as_res, as_dres;
    logic              as_c, as_v, as_neg, as_dc;
    logic [LANES-1:0]  as_lovf, as_lneg;

    logic [DATA_W-1:0] sh_res;
    logic              sh_v, sh_neg;

    logic [DATA_W-1:0] pre_res, post_res;
    logic              pre_v, pre_neg, pre_dual, post_v, do_rnd, do_sat;

    alu_out_t st_d, st_q;

    assign op    = alu_op_e'(op_i);
    assign b_eff = imm_sel_i ? {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : acc_b_i;

    alu40_addsub #(.W(DATA_W), .L(LANE_W), .NLANE(LANES)) u_addsub (
        .a_i        (acc_a_i),
        .b_i        (b_eff),
        .sub_i      (op == OP_SUB),
        .res_o      (as_res),
        .carry_o    (as_c),
        .ovf_o      (as_v),
        .neg_o      (as_neg),
        .dres_o     (as_dres),
        .dcarry_o   (as_dc),
        .lane_ovf_o (as_lovf),
        .lane_neg_o (as_lneg)
    );

    alu40_shifter #(.W(DATA_W), .SW(SHIFT_W)) u_shift (
        .a_i   (acc_a_i),
        .cnt_i (shamt_i),
        .res_o (sh_res),
        .ovf_o (sh_v),
        .neg_o (sh_neg)
    );

    // pick the arithmetic source that feeds rounding and saturation
    always_comb begin
        pre_dual = 1'b0;
        do_rnd   = 1'b0;
        do_sat   = 1'b0;
        pre_res  = as_res;
        pre_v    = as_v;
        pre_neg  = as_neg;
        if (op == OP_ADD || op == OP_SUB) begin
            do_rnd = rnd_i;
            do_sat = sat_i;
            if (dual_i) begin
                pre_dual = 1'b1;
                pre_res  = as_dres;
                pre_v    = |as_lovf;
            end
        end else if (op == OP_SHIFT) begin
            do_rnd  = rnd_i;
            do_sat  = sat_i;
            pre_res = sh_res;
            pre_v   = sh_v;
            pre_neg = sh_neg;
        end
    end

    alu40_post #(.W(DATA_W), .L(LANE_W), .SATW(SAT_W), .NLANE(LANES)) u_post (
        .res_i      (pre_res),
        .ovf_i      (pre_v),
        .neg_i      (pre_neg),
        .dual_i     (pre_dual),
        .lane_ovf_i (as_lovf),
        .lane_neg_i (as_lneg),
        .rnd_i      (do_rnd),
        .sat_i      (do_sat),
        .res_o      (post_res),
        .ovf_o      (post_v)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_ADD, OP_SUB: begin
                st_d.res   = post_res;
                st_d.carry = dual_i ? as_dc : as_c;
                st_d.ovf   = post_v;
            end
            OP_SHIFT: begin
                st_d.res   = post_res;
                st_d.carry = 1'b0;
                st_d.ovf   = post_v;
            end
            OP_AND: begin
                st_d.res   = acc_a_i & b_eff;
                st_d.carry = 1'b0;
                st_d.ovf   = 1'b0;
            end
            OP_OR: begin
                st_d.res   = acc_a_i | b_eff;
                st_d.carry = 1'b0;
                st_d.ovf   = 1'b0;
            end
            OP_XOR: begin
                st_d.res   = acc_a_i ^ b_eff;
                st_d.carry = 1'b0;
                st_d.ovf   = 1'b0;
            end
            default: begin
                st_d.res   = b_eff;
                st_d.carry = 1'b0;
                st_d.ovf   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign carry_o  = st_q.carry;
    assign ovf_o    = st_q.ovf;
endmodule

// File: rtl/alu40_checks.sv
module alu40_checks
    import alu40_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [OP_W-1:0]     op_i,
    input logic                dual_i,
    input logic                sat_i,
    input logic                rnd_i,
    input logic                imm_sel_i,
    input logic [IMM_W-1:0]    imm_i,
    input logic [SHIFT_W-1:0]  shamt_i,
    input logic [DATA_W-1:0]   acc_a_i,
    input logic [DATA_W-1:0]   result_o,
    input logic                carry_o,
    input logic                ovf_o
);
    a_r4_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4) |=> (!carry_o && !ovf_o));

    a_r7_dual_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_i && op_i[2:1] == 2'b00) |=>
        (result_o[DATA_W-1:SAT_W] == {(DATA_W-SAT_W){result_o[SAT_W-1]}}));

    a_r8_round_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && rnd_i && !sat_i && (op_i[2:1] == 2'b00 || op_i == 3'd5)) |=>
        (result_o[LANE_W-1:0] == '0));

    a_r9_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && sat_i && (op_i[2:1] == 2'b00 || op_i == 3'd5)) |=>
        ((&result_o[DATA_W-1:SAT_W-1]) || !(|result_o[DATA_W-1:SAT_W-1])));

    a_r5_move_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2:1] == 2'b11 && imm_sel_i) |=>
        (result_o == {{(DATA_W-IMM_W){$past(imm_i[IMM_W-1])}}, $past(imm_i)} && !ovf_o));

    a_r6_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && shamt_i == '0 && !rnd_i && !sat_i) |=>
        (result_o == $past(acc_a_i) && !ovf_o && !carry_o));
endmodule

bind dsp_alu40 alu40_checks u_alu40_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .dual_i    (dual_i),
    .sat_i     (sat_i),
    .rnd_i     (rnd_i),
    .imm_sel_i (imm_sel_i),
    .imm_i     (imm_i),
    .shamt_i   (shamt_i),
    .acc_a_i   (acc_a_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o)
);

// File: tb/test_dsp_alu40.sv
`timescale 1ns/1ps
module test_dsp_alu40;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        dual_i = 1'b0, sat_i = 1'b0, rnd_i = 1'b0, imm_sel_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [5:0]  shamt_i = '0;
    logic [39:0] acc_a_i = '0, acc_b_i = '0;
    logic [39:0] result_o;
    logic        carry_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dsp_alu40 i_dsp_alu40 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dual_i(dual_i), .sat_i(sat_i),
        .rnd_i(rnd_i), .imm_sel_i(imm_sel_i), .imm_i(imm_i), .shamt_i(shamt_i),
        .acc_a_i(acc_a_i), .acc_b_i(acc_b_i),
        .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic        dual, sat, rnd, isel;
        logic [15:0] imm;
        logic [5:0]  sh;
        logic [39:0] a, b, er;
        logic        ec, ev;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h5, 40'h3, 40'h8, 1'b0, 1'b0},                                // R2
        '{4'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h7FFFFFFFFF, 40'h1, 40'h8000000000, 1'b0, 1'b1},            // R3
        '{4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'hFFFFFFFFFF, 40'h1, 40'h0, 1'b1, 1'b0},                     // R2
        '{4'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h5, 40'h3, 40'h2, 1'b1, 1'b0},                              // R2
        '{4'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h3, 40'h5, 40'hFFFFFFFFFE, 1'b0, 1'b0},                     // R2
        '{4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h8000000000, 40'h1, 40'h7FFFFFFFFF, 1'b1, 1'b1},            // R3
        '{4'd4, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'hF0F0F0F0F0, 40'hFF00FF00FF, 40'hF000F000F0, 1'b0, 1'b0},   // R4
        '{4'd4, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'hF0F0F0F0F0, 40'hFF00FF00FF, 40'hFFF0FFF0FF, 1'b0, 1'b0},   // R4
        '{4'd4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'hF0F0F0F0F0, 40'hFF00FF00FF, 40'h0FF00FF00F, 1'b0, 1'b0},   // R4
        '{4'd5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 6'd0, 40'h10, 40'h1234, 40'hF, 1'b1, 1'b0},                       // R5
        '{4'd6, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd31, 40'h1, 40'h0, 40'h0080000000, 1'b0, 1'b0},                    // R6
        '{4'd6, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'b100000, 40'h8000000000, 40'h0, 40'hFFFFFFFF80, 1'b0, 1'b0},       // R6
        '{4'd6, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'b111100, 40'h0012345678, 40'h0, 40'h0001234567, 1'b0, 1'b0},       // R6
        '{4'd6, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 6'd10, 40'h0040000000, 40'h0, 40'h0, 1'b0, 1'b1},                    // R6
        '{4'd7, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 6'd0, 40'h007FFF0001, 40'h000001FFFF, 40'hFF80000000, 1'b0, 1'b1},   // R7
        '{4'd10, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 6'd0, 40'h007FFF0001, 40'h000001FFFF, 40'h007FFF0000, 1'b0, 1'b1},  // R10
        '{4'd10, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 6'd0, 40'h0000008000, 40'h0000010001, 40'hFFFFFF8000, 1'b0, 1'b1},  // R10
        '{4'd8, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 6'd0, 40'h0000018000, 40'h0, 40'h0000020000, 1'b0, 1'b0},            // R8
        '{4'd8, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 6'd0, 40'h0000017FFF, 40'h0, 40'h0000010000, 1'b0, 1'b0},            // R8
        '{4'd9, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 6'd0, 40'h007FFFFFFF, 40'h1, 40'h007FFFFFFF, 1'b0, 1'b0},            // R9
        '{4'd9, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 6'd0, 40'hFF80000000, 40'h1, 40'hFF80000000, 1'b1, 1'b0},            // R9
        '{4'd9, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 6'd0, 40'h7FFFFFFFFF, 40'h1, 40'h007FFFFFFF, 1'b0, 1'b1},            // R9
        '{4'd8, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 6'd0, 40'h0000010002, 40'h0000030004, 40'h0000040006, 1'b0, 1'b0},   // R8 skipped in dual
        '{4'd5, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8001, 6'd0, 40'h55, 40'h77, 40'hFFFFFF8001, 1'b0, 1'b0},                // R5
        '{4'd4, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 6'd0, 40'h123456789A, 40'hFFFFFFFFFF, 40'h123456789A, 1'b0, 1'b0},   // R4
        '{4'd9, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 6'd16, 40'h0000010000, 40'h0, 40'h007FFFFFFF, 1'b0, 1'b0},           // R9
        '{4'd7, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 6'd1, 40'h000000FFFF, 40'h0, 40'h000001FFFE, 1'b0, 1'b0}             // R7
    };

    task automatic check(input string req, input logic [41:0] act, input logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                     req, act[41:2], act[1], act[0], exp[41:2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i = v.op; dual_i = v.dual; sat_i = v.sat; rnd_i = v.rnd;
        imm_sel_i = v.isel; imm_i = v.imm; shamt_i = v.sh;
        acc_a_i = v.a; acc_b_i = v.b;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {result_o, carry_o, ovf_o}, 42'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  {result_o, carry_o, ovf_o}, {VECS[i].er, VECS[i].ec, VECS[i].ev});
        end

        // R1: result held until the next rising edge
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        drive(VECS[1]);
        #1;
        check("R1 hold", {result_o, carry_o, ovf_o}, {40'h8, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        check("R1 update", {result_o, carry_o, ovf_o}, {40'h8000000000, 1'b0, 1'b1});

        // R1: asynchronous clear between edges
        drive(VECS[2]);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check("R1 async reset", {result_o, carry_o, ovf_o}, 42'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: zero count passes A unchanged
        op_i = 3'd5; shamt_i = 6'd0; sat_i = 1'b0; rnd_i = 1'b0; dual_i = 1'b0;
        acc_a_i = 40'hA5A5A5A5A5;
        @(posedge clk);
        @(negedge clk);
        check("R6 zero shift", {result_o, carry_o, ovf_o}, {40'hA5A5A5A5A5, 1'b0, 1'b0});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule